// File: doc/BRIEF.md
# LCD Frame Fetch and Palette Sequencer

This block sits in front of an LCD pixel pipeline and decides, once per frame, where and how the frame buffer is read. When a frame starts it can pull a 256-entry, 16-bit colour palette from the head of the current buffer, a word at a time. It writes each word to an external palette RAM. The pixel depth is not held in a register. It is read from bits 14:12 of the first palette word, so the software that fills the buffer also chooses the pixel format.

From that depth and the configured panel size, the block works out several results in one cycle: the header length to skip, the number of bytes per line, the range of lines to fetch and the first fetch address. It checks that the frame fits inside the buffer window. If it does not, the block reports a sync error and stops. Each frame that passes raises a per-buffer DMA condition strobe and, when enabled, an interrupt strobe. In dual-buffer mode the block switches between two buffers from frame to frame.

Enabling the sequencer checks the buffer addresses first. An invalid window raises a separate condition strobe and keeps the block stopped.

Top module: `lcd_frame_seq`

## Requirements
- R1: Unless `pal_mode_i` is 2, each accepted frame issues 256 reads at byte addresses top, top+2, …, top+510 of the current buffer. Each returned word (one cycle after its read) is written to the palette port with index 0 to 255 in order. With `pal_mode_i` equal to 2 there are no reads and no palette writes.
- R2: The depth code is bits 14:12 of palette word 0. Code 1 gives 2 bpp, code 2 gives 4 bpp, code 3 gives 8 bpp and codes 4 to 7 give 16 bpp. Code 0 pulses `skip_o` and produces no frame strobe and no condition strobe. With `pal_mode_i` equal to 2, the code from the most recent palette load is used.
- R3: The header offset is 0x200 bytes for codes 3 to 7, 0x20 bytes for codes 1 and 2, and 0 when `pal_mode_i` is 2.
- R4: If offset + width·height·bpp/8 is greater than bottom − top + 2 of the current buffer, `sync_err_o` pulses, `running_o` falls and no frame strobe occurs. Equality passes.
- R5: `step_o` = width·bpp/8. `start_addr_o` = top + offset + `step_o`·first line.
- R6: With `sp_en_i` set, `sp_line_i` is the first line when `sp_from_i` is 1, and the line count (`end_line_o`) when it is 0. Otherwise the first line is 0 and the end is the height.
- R7: A fetched frame pulses `frame_ok_o` together with `dma_cond_o` bit n for current buffer n. `dma_irq_o` pulses only if `dma_ie_i[0]` is 1.
- R8: In dual mode the buffer index toggles after every fetched frame. A rising `en_i` resets the index to 0.
- R9: On a rising `en_i`, buffer 0's top/bottom valid flags (`addr_ok_i[1:0]`) are checked, plus buffer 1's (`addr_ok_i[3:2]`) in dual mode. On failure, `dma_cond_o[2]` pulses, `dma_irq_o` pulses if `dma_ie_i[1]` is set, and the block stays stopped. Flags of an unused buffer are ignored.
- R10: `pal_done_o` pulses at the end of the first palette load after each enable, and not on later loads.
- R11: `mode12_o` is 1 for a 16 bpp frame when `tft_i` is 0, and 0 otherwise.
- R12: `busy_o` is high from frame acceptance until the results are out. `frame_start_i` is ignored while stopped or busy.
- R13: After reset the block is stopped and idle, with no reads and no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| en_i | input | 1 | controller enable level |
| pal_mode_i | input | 2 | palette mode, 2 = no palette |
| tft_i | input | 1 | active-matrix panel |
| dual_i | input | 1 | alternate between two buffers |
| width_i | input | DIM_W | pixels per line |
| height_i | input | DIM_W | lines per frame |
| sp_en_i | input | 1 | subpanel limit on |
| sp_from_i | input | 1 | subpanel line is first line (1) or count (0) |
| sp_line_i | input | 10 | subpanel line number |
| top0_i | input | ADDR_W | buffer 0 first byte |
| bot0_i | input | ADDR_W | buffer 0 last address |
| top1_i | input | ADDR_W | buffer 1 first byte |
| bot1_i | input | ADDR_W | buffer 1 last address |
| addr_ok_i | input | 4 | valid flags: top0, bot0, top1, bot1 |
| dma_ie_i | input | 2 | bit0 frame irq, bit1 address-error irq |
| frame_start_i | input | 1 | frame start pulse |
| mem_rd_o | output | 1 | word read request |
| mem_addr_o | output | ADDR_W | read byte address |
| mem_rdata_i | input | 16 | read data, one cycle after request |
| pal_we_o | output | 1 | palette write |
| pal_idx_o | output | 8 | palette index |
| pal_data_o | output | 16 | palette word |
| busy_o | output | 1 | frame setup in progress |
| running_o | output | 1 | controller active |
| buf_idx_o | output | 1 | current buffer |
| start_addr_o | output | ADDR_W | first pixel fetch address |
| step_o | output | DIM_W+1 | bytes per line |
| first_line_o | output | DIM_W | first line fetched |
| end_line_o | output | DIM_W | line limit (exclusive) |
| bpp_o | output | 5 | bits per pixel |
| mode12_o | output | 1 | 16 bpp data is 12-bit |
| frame_ok_o | output | 1 | frame fetch strobe |
| skip_o | output | 1 | unsupported depth strobe |
| sync_err_o | output | 1 | size error strobe |
| pal_done_o | output | 1 | first palette loaded strobe |
| dma_cond_o | output | 3 | condition strobes: buf0, buf1, address error |
| dma_irq_o | output | 1 | DMA interrupt strobe |

## Verification
The bench places the frame size exactly at the buffer limit and one byte past it. A design off by one in the "+2" slack or in the comparison would fail the first case or fetch in the second. It runs a no-palette frame after a palette load whose code differs from the code stored in memory. A design that reread memory, or reset the code, would report the wrong depth. It covers dual-buffer alternation, index reset on re-enable, and address checking that must ignore buffer 1 in single mode. A wrong design would read palettes from the wrong buffer, strand the index at 1, or refuse a valid configuration. Both subpanel interpretations and code 0 are also driven. A swapped field would move the start address or line range, and a missing skip would raise a spurious condition strobe.

// File: rtl/lcdfs_pkg.sv
package lcdfs_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LOAD = 2'd1,
        SQ_CALC = 2'd2
    } sq_state_e;

    // depth code from palette word 0 -> bits per pixel (0 = unsupported)
    function automatic logic [4:0] code_to_bpp(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd0;
            3'd1:    return 5'd2;
            3'd2:    return 5'd4;
            3'd3:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/lcdfs_pal_loader.sv
module lcdfs_pal_loader #(
    parameter int ADDR_W = 24,
    parameter int WORDS  = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [ADDR_W-1:0]        base_i,
    output logic                     mem_rd_o,
    output logic [ADDR_W-1:0]        mem_addr_o,
    input  logic [15:0]              mem_rdata_i,
    output logic                     pal_we_o,
    output logic [$clog2(WORDS)-1:0] pal_idx_o,
    output logic [15:0]              pal_data_o,
    output logic                     done_o
);
    localparam int CNT_W = $clog2(WORDS);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] base;
        logic              wv;
        logic [CNT_W-1:0]  widx;
    } ld_t;

    ld_t q, d;

    always_comb begin
        d      = q;
        d.wv   = q.active;
        d.widx = q.cnt;
        if (start_i) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.base   = base_i;
        end else if (q.active) begin
            if (q.cnt == CNT_W'(WORDS - 1)) d.active = 1'b0;
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_rd_o   = q.active;
    assign mem_addr_o = q.base + ADDR_W'({q.cnt, 1'b0});
    assign pal_we_o   = q.wv;
    assign pal_idx_o  = q.widx;
    assign pal_data_o = mem_rdata_i;
    assign done_o     = q.wv && (q.widx == CNT_W'(WORDS - 1));

    // R1: palette indices are written in ascending order
    a_r1_idx_order: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we_o && $past(pal_we_o) && pal_idx_o != '0
        |-> pal_idx_o == $past(pal_idx_o) + 1'b1);

    // R1: consecutive reads advance by one 16-bit word
    a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o && $past(mem_rd_o) && !$past(start_i)
        |-> mem_addr_o == $past(mem_addr_o) + ADDR_W'(2));

endmodule

// File: rtl/lcdfs_geom.sv
module lcdfs_geom
    import lcdfs_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DIM_W     = 11,
    parameter int LINE_W    = 10,
    parameter int PAL_BYTES = 512,
    parameter int SHORT_HDR = 32
) (
    input  logic [2:0]        code_i,
    input  logic              no_pal_i,
    input  logic              tft_i,
    input  logic [DIM_W-1:0]  width_i,
    input  logic [DIM_W-1:0]  height_i,
    input  logic              sp_en_i,
    input  logic              sp_from_i,
    input  logic [LINE_W-1:0] sp_line_i,
    input  logic [ADDR_W-1:0] top_i,
    input  logic [ADDR_W-1:0] bot_i,
    output logic [4:0]        bpp_o,
    output logic [DIM_W:0]    step_o,
    output logic [DIM_W-1:0]  first_o,
    output logic [DIM_W-1:0]  end_o,
    output logic [ADDR_W-1:0] start_o,
    output logic              fits_o,
    output logic              valid_o,
    output logic              mode12_o
);
    localparam int STEP_W = DIM_W + 1;
    localparam int RB_W   = DIM_W + 5;
    localparam int PROD_W = 2 * DIM_W + 5;
    localparam int CMP_W  = ((PROD_W > ADDR_W) ? PROD_W : ADDR_W) + 2;
    localparam int SKP_W  = STEP_W + DIM_W;

    logic [ADDR_W-1:0] off;
    logic [PROD_W-1:0] pix_bits;
    logic [RB_W-1:0]   row_bits;
    logic [CMP_W-1:0]  need, avail;
    logic [SKP_W-1:0]  skip_bytes;

    assign bpp_o   = code_to_bpp(code_i);
    assign valid_o = (code_i != 3'd0);

    always_comb begin
        if (no_pal_i)            off = '0;
        else if (code_i >= 3'd3) off = ADDR_W'(PAL_BYTES);
        else                     off = ADDR_W'(SHORT_HDR);
    end

    always_comb begin
        first_o = '0;
        end_o   = height_i;
        if (sp_en_i) begin
            if (sp_from_i) first_o = DIM_W'(sp_line_i);
            else           end_o   = DIM_W'(sp_line_i);
        end
    end

    assign pix_bits   = PROD_W'(width_i) * PROD_W'(height_i) * PROD_W'(bpp_o);
    assign need       = CMP_W'(off) + CMP_W'(pix_bits >> 3);
    assign avail      = CMP_W'(bot_i) - CMP_W'(top_i) + CMP_W'(2);
    assign fits_o     = (need <= avail);

    assign row_bits   = RB_W'(width_i) * RB_W'(bpp_o);
    assign step_o     = STEP_W'(row_bits >> 3);
    assign skip_bytes = SKP_W'(step_o) * SKP_W'(first_o);
    assign start_o    = top_i + off + ADDR_W'(skip_bytes);

    assign mode12_o   = (bpp_o == 5'd16) && !tft_i;

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lcdfs_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DIM_W     = 11,
    parameter int PAL_N     = 256,
    parameter int SHORT_HDR = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_i,
    input  logic [1:0]               pal_mode_i,
    input  logic                     tft_i,
    input  logic                     dual_i,
    input  logic [DIM_W-1:0]         width_i,
    input  logic [DIM_W-1:0]         height_i,
    input  logic                     sp_en_i,
    input  logic                     sp_from_i,
    input  logic [9:0]               sp_line_i,
    input  logic [ADDR_W-1:0]        top0_i,
    input  logic [ADDR_W-1:0]        bot0_i,
    input  logic [ADDR_W-1:0]        top1_i,
    input  logic [ADDR_W-1:0]        bot1_i,
    input  logic [3:0]               addr_ok_i,
    input  logic [1:0]               dma_ie_i,
    input  logic                     frame_start_i,
    output logic                     mem_rd_o,
    output logic [ADDR_W-1:0]        mem_addr_o,
    input  logic [15:0]              mem_rdata_i,
    output logic                     pal_we_o,
    output logic [$clog2(PAL_N)-1:0] pal_idx_o,
    output logic [15:0]              pal_data_o,
    output logic                     busy_o,
    output logic                     running_o,
    output logic                     buf_idx_o,
    output logic [ADDR_W-1:0]        start_addr_o,
    output logic [DIM_W:0]           step_o,
    output logic [DIM_W-1:0]         first_line_o,
    output logic [DIM_W-1:0]         end_line_o,
    output logic [4:0]               bpp_o,
    output logic                     mode12_o,
    output logic                     frame_ok_o,
    output logic                     skip_o,
    output logic                     sync_err_o,
    output logic                     pal_done_o,
    output logic [2:0]               dma_cond_o,
    output logic                     dma_irq_o
);
    localparam int STEP_W    = DIM_W + 1;
    localparam int PIDX_W    = $clog2(PAL_N);
    localparam int PAL_BYTES = 2 * PAL_N;

    typedef struct packed {
        sq_state_e         st;
        logic              run;
        logic              en_seen;
        logic              idx;
        logic              pal_loaded;
        logic [2:0]        code;
        logic [ADDR_W-1:0] top;
        logic [ADDR_W-1:0] bot;
        logic [ADDR_W-1:0] start;
        logic [STEP_W-1:0] step;
        logic [DIM_W-1:0]  first;
        logic [DIM_W-1:0]  endl;
        logic [4:0]        bpp;
        logic              mode12;
        logic              ok;
        logic              skip;
        logic              sync;
        logic              pdone;
        logic [2:0]        cond;
        logic              irq;
    } seq_t;

    seq_t q, d;

    logic              ld_start, ld_done;
    logic              addr_bad;
    logic [4:0]        g_bpp;
    logic [STEP_W-1:0] g_step;
    logic [DIM_W-1:0]  g_first, g_end;
    logic [ADDR_W-1:0] g_start;
    logic              g_fits, g_valid, g_mode12;

    lcdfs_pal_loader #(.ADDR_W(ADDR_W), .WORDS(PAL_N)) u_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (ld_start),
        .base_i      (d.top),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .mem_rdata_i (mem_rdata_i),
        .pal_we_o    (pal_we_o),
        .pal_idx_o   (pal_idx_o),
        .pal_data_o  (pal_data_o),
        .done_o      (ld_done)
    );

    lcdfs_geom #(
        .ADDR_W(ADDR_W), .DIM_W(DIM_W), .LINE_W(10),
        .PAL_BYTES(PAL_BYTES), .SHORT_HDR(SHORT_HDR)
    ) u_geom (
        .code_i    (q.code),
        .no_pal_i  (pal_mode_i == 2'd2),
        .tft_i     (tft_i),
        .width_i   (width_i),
        .height_i  (height_i),
        .sp_en_i   (sp_en_i),
        .sp_from_i (sp_from_i),
        .sp_line_i (sp_line_i),
        .top_i     (q.top),
        .bot_i     (q.bot),
        .bpp_o     (g_bpp),
        .step_o    (g_step),
        .first_o   (g_first),
        .end_o     (g_end),
        .start_o   (g_start),
        .fits_o    (g_fits),
        .valid_o   (g_valid),
        .mode12_o  (g_mode12)
    );

    assign addr_bad = !addr_ok_i[0] || !addr_ok_i[1] ||
                      (dual_i && (!addr_ok_i[2] || !addr_ok_i[3]));

    always_comb begin
        d         = q;
        ld_start  = 1'b0;
        d.ok      = 1'b0;
        d.skip    = 1'b0;
        d.sync    = 1'b0;
        d.pdone   = 1'b0;
        d.cond    = 3'b000;
        d.irq     = 1'b0;
        d.en_seen = en_i;

        case (q.st)
            SQ_IDLE: begin
                if (q.run && en_i && frame_start_i) begin
                    d.top = q.idx ? top1_i : top0_i;
                    d.bot = q.idx ? bot1_i : bot0_i;
                    if (pal_mode_i != 2'd2) begin
                        d.st     = SQ_LOAD;
                        ld_start = 1'b1;
                    end else begin
                        d.st = SQ_CALC;
                    end
                end
            end
            SQ_LOAD: begin
                if (pal_we_o && pal_idx_o == '0) d.code = pal_data_o[14:12];
                if (ld_done) begin
                    d.st = SQ_CALC;
                    if (!q.pal_loaded) begin
                        d.pdone      = 1'b1;
                        d.pal_loaded = 1'b1;
                    end
                end
            end
            SQ_CALC: begin
                d.st = SQ_IDLE;
                if (!g_valid) begin
                    d.skip = 1'b1;
                end else if (!g_fits) begin
                    d.sync = 1'b1;
                    d.run  = 1'b0;
                end else begin
                    d.ok          = 1'b1;
                    d.start       = g_start;
                    d.step        = g_step;
                    d.first       = g_first;
                    d.endl        = g_end;
                    d.bpp         = g_bpp;
                    d.mode12      = g_mode12;
                    d.cond[q.idx] = 1'b1;
                    d.irq         = dma_ie_i[0];
                    if (dual_i) d.idx = ~q.idx;
                end
            end
            default: d.st = SQ_IDLE;
        endcase

        if (!en_i && q.en_seen) begin
            d.run = 1'b0;
            d.st  = SQ_IDLE;
        end else if (en_i && !q.en_seen) begin
            if (addr_bad) begin
                d.cond[2] = 1'b1;
                d.irq     = dma_ie_i[1];
                d.run     = 1'b0;
            end else begin
                d.run        = 1'b1;
                d.idx        = 1'b0;
                d.pal_loaded = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o       = (q.st != SQ_IDLE);
    assign running_o    = q.run;
    assign buf_idx_o    = q.idx;
    assign start_addr_o = q.start;
    assign step_o       = q.step;
    assign first_line_o = q.first;
    assign end_line_o   = q.endl;
    assign bpp_o        = q.bpp;
    assign mode12_o     = q.mode12;
    assign frame_ok_o   = q.ok;
    assign skip_o       = q.skip;
    assign sync_err_o   = q.sync;
    assign pal_done_o   = q.pdone;
    assign dma_cond_o   = q.cond;
    assign dma_irq_o    = q.irq;

    // R4: a size error leaves the controller stopped
    a_r4_sync_stops: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err_o |-> !running_o && !frame_ok_o);

    // R7: a fetched frame marks exactly one buffer condition
    a_r7_one_cond: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok_o |-> $countones(dma_cond_o[1:0]) == 1 && !dma_cond_o[2]);

    // R9: an address error never starts the controller
    a_r9_bad_addr_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        dma_cond_o[2] |-> !running_o);

    // R8: dual mode switches buffers on every fetched frame
    a_r8_dual_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok_o && $past(dual_i) |-> buf_idx_o != $past(buf_idx_o));

    // R12: frame setup only proceeds while running
    a_r12_busy_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> running_o);

    // R2: a skipped frame raises no fetch strobe
    a_r2_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> !frame_ok_o && dma_cond_o == 3'b000);

endmodule

// File: tb/sim_lcd_frame_seq.sv
`timescale 1ns/1ps
module sim_lcd_frame_seq;
    localparam int ADDR_W = 24;
    localparam int DIM_W  = 11;

    typedef struct packed {
        logic [2:0]  code;
        logic [1:0]  pm;
        logic        tft;
        logic [10:0] w;
        logic [10:0] h;
        logic        sp_en;
        logic        sp_from;
        logic [9:0]  sp_line;
        logic [23:0] bot;
        logic [1:0]  kind;   // 0 fetch, 1 skip, 2 sync error
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{3'd1, 2'd0, 1'b0, 11'd64, 11'd16, 1'b0, 1'b0, 10'd0,  24'h001000, 2'd0},
        '{3'd2, 2'd0, 1'b0, 11'd32, 11'd8,  1'b1, 1'b1, 10'd3,  24'h001000, 2'd0},
        '{3'd3, 2'd0, 1'b0, 11'd40, 11'd20, 1'b1, 1'b0, 10'd12, 24'h001000, 2'd0},
        '{3'd5, 2'd0, 1'b0, 11'd16, 11'd10, 1'b0, 1'b0, 10'd0,  24'h001000, 2'd0},
        '{3'd7, 2'd0, 1'b1, 11'd16, 11'd10, 1'b0, 1'b0, 10'd0,  24'h001000, 2'd0},
        '{3'd0, 2'd0, 1'b0, 11'd16, 11'd10, 1'b0, 1'b0, 10'd0,  24'h001000, 2'd1},
        '{3'd4, 2'd0, 1'b0, 11'd8,  11'd4,  1'b0, 1'b0, 10'd0,  24'h001000, 2'd0},
        '{3'd1, 2'd2, 1'b1, 11'd8,  11'd4,  1'b0, 1'b0, 10'd0,  24'h001000, 2'd0},
        '{3'd3, 2'd0, 1'b0, 11'd16, 11'd16, 1'b0, 1'b0, 10'd0,  24'h0002FE, 2'd0},
        '{3'd3, 2'd0, 1'b0, 11'd16, 11'd16, 1'b0, 1'b0, 10'd0,  24'h0002FD, 2'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, tft = 1'b0, dual = 1'b0, sp_en = 1'b0, sp_from = 1'b0, fstart = 1'b0;
    logic [1:0] pm = 2'd0, ie = 2'b11;
    logic [10:0] w = 11'd8, h = 11'd4;
    logic [9:0] sp_line = 10'd0;
    logic [23:0] top0 = 24'h0, bot0 = 24'h1000, top1 = 24'h1000, bot1 = 24'h1FFE;
    logic [3:0] aok = 4'hF;
    logic mem_rd, pal_we, busy, running, buf_idx, mode12, f_ok, skip, serr, pdone, irq;
    logic [23:0] mem_addr, start_addr;
    logic [15:0] mem_rdata, pal_data;
    logic [7:0] pal_idx;
    logic [11:0] step;
    logic [10:0] first_line, end_line;
    logic [4:0] bpp;
    logic [2:0] cond;

    logic [15:0] mem [0:4095];
    logic [15:0] pal_m [0:255];
    int c_ok = 0, c_skip = 0, c_sync = 0, c_pd = 0, c_irq = 0, c_c0 = 0, c_c1 = 0, c_c2 = 0, c_pw = 0;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lcd_frame_seq #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .pal_mode_i(pm), .tft_i(tft), .dual_i(dual),
        .width_i(w), .height_i(h), .sp_en_i(sp_en), .sp_from_i(sp_from), .sp_line_i(sp_line),
        .top0_i(top0), .bot0_i(bot0), .top1_i(top1), .bot1_i(bot1), .addr_ok_i(aok),
        .dma_ie_i(ie), .frame_start_i(fstart), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
        .mem_rdata_i(mem_rdata), .pal_we_o(pal_we), .pal_idx_o(pal_idx), .pal_data_o(pal_data),
        .busy_o(busy), .running_o(running), .buf_idx_o(buf_idx), .start_addr_o(start_addr),
        .step_o(step), .first_line_o(first_line), .end_line_o(end_line), .bpp_o(bpp),
        .mode12_o(mode12), .frame_ok_o(f_ok), .skip_o(skip), .sync_err_o(serr),
        .pal_done_o(pdone), .dma_cond_o(cond), .dma_irq_o(irq)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[12:1]];
        if (pal_we) begin pal_m[pal_idx] <= pal_data; c_pw++; end
        if (f_ok) c_ok++;
        if (skip) c_skip++;
        if (serr) c_sync++;
        if (pdone) c_pd++;
        if (irq) c_irq++;
        if (cond[0]) c_c0++;
        if (cond[1]) c_c1++;
        if (cond[2]) c_c2++;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic set_en(input logic v);
        @(negedge clk); en = v;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic run_frame();
        @(negedge clk); fstart = 1'b1;
        @(negedge clk); fstart = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            if (!busy) break;
            @(negedge clk);
        end
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        wrap_up();
    end

    initial begin
        int s_ok, s_skip, s_sync, s_pd, s_irq, s_c0, s_c1, s_c2, s_pw;
        int last_code, eff, ebpp, eoff, estep, efirst, eend, mism;
        for (int k = 0; k < 4096; k++) mem[k] = 16'(k * 37 + 5);
        mem_rdata = 16'h0;
        repeat (4) @(negedge clk);
        // R13: reset state
        chk("R13 busy", busy, 0);
        chk("R13 running", running, 0);
        chk("R13 mem_rd", mem_rd, 0);
        chk("R13 frame_ok", f_ok, 0);
        rst_n = 1'b1;
        @(negedge clk);
        set_en(1'b1);
        chk("R9 enable with valid addresses", running, 1);

        last_code = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            pm = VECS[i].pm; tft = VECS[i].tft; w = VECS[i].w; h = VECS[i].h;
            sp_en = VECS[i].sp_en; sp_from = VECS[i].sp_from; sp_line = VECS[i].sp_line;
            bot0 = VECS[i].bot;
            mem[0] = {1'b0, VECS[i].code, 12'h5A5};
            s_ok = c_ok; s_skip = c_skip; s_sync = c_sync; s_pd = c_pd; s_irq = c_irq;
            s_c0 = c_c0; s_pw = c_pw;
            run_frame();
            if (VECS[i].pm != 2'd2) last_code = int'(VECS[i].code);
            eff   = last_code;
            ebpp  = (eff == 1) ? 2 : (eff == 2) ? 4 : (eff == 3) ? 8 : 16;
            eoff  = (VECS[i].pm == 2'd2) ? 0 : ((eff >= 3) ? 'h200 : 'h20);
            estep = int'(VECS[i].w) * ebpp / 8;
            efirst = (VECS[i].sp_en && VECS[i].sp_from) ? int'(VECS[i].sp_line) : 0;
            eend   = (VECS[i].sp_en && !VECS[i].sp_from) ? int'(VECS[i].sp_line) : int'(VECS[i].h);
            chk("R1 palette writes", c_pw - s_pw, (VECS[i].pm == 2'd2) ? 0 : 256);
            chk("R10 pal_done once", c_pd - s_pd, (i == 0) ? 1 : 0);
            if (VECS[i].kind == 2'd0) begin
                chk("R7 frame_ok", c_ok - s_ok, 1);
                chk("R7 cond0", c_c0 - s_c0, 1);
                chk("R7 irq", c_irq - s_irq, 1);
                chk("R2 bpp", bpp, ebpp);
                chk("R5 step", step, estep);
                chk("R6 first line", first_line, efirst);
                chk("R6 end line", end_line, eend);
                chk("R3 R5 start addr", start_addr, eoff + estep * efirst);
                chk("R11 mode12", mode12, (ebpp == 16 && !VECS[i].tft) ? 1 : 0);
            end else if (VECS[i].kind == 2'd1) begin
                chk("R2 skip strobe", c_skip - s_skip, 1);
                chk("R2 no fetch on code 0", (c_ok - s_ok) + (c_c0 - s_c0), 0);
            end else begin
                chk("R4 sync error", c_sync - s_sync, 1);
                chk("R4 no fetch", c_ok - s_ok, 0);
                chk("R4 stopped", running, 0);
            end
            if (i == 0) begin
                mism = 0;
                for (int k = 0; k < 256; k++) if (pal_m[k] !== mem[k]) mism++;
                chk("R1 palette content buf0", mism, 0);
            end
        end

        // R12: frame start ignored while stopped
        s_pw = c_pw; s_ok = c_ok;
        run_frame();
        chk("R12 no load while stopped", c_pw - s_pw, 0);
        chk("R12 no frame while stopped", c_ok - s_ok, 0);

        // R9: invalid address on enable
        set_en(1'b0);
        aok = 4'b1110; s_c2 = c_c2; s_irq = c_irq;
        set_en(1'b1);
        chk("R9 cond2", c_c2 - s_c2, 1);
        chk("R9 irq on address error", c_irq - s_irq, 1);
        chk("R9 stays stopped", running, 0);
        set_en(1'b0);
        aok = 4'b1011; dual = 1'b0;
        set_en(1'b1);
        chk("R9 unused buffer flags ignored", running, 1);
        set_en(1'b0);
        dual = 1'b1; s_c2 = c_c2;
        set_en(1'b1);
        chk("R9 dual checks buffer 1", running, 0);
        chk("R9 dual cond2", c_c2 - s_c2, 1);
        set_en(1'b0);

        // R8/R10/R1: dual alternation
        aok = 4'hF; ie = 2'b00; pm = 2'd0; tft = 1'b0; w = 11'd16; h = 11'd8; sp_en = 1'b0;
        bot0 = 24'h0FFE; mem[0] = 16'h2000; mem[12'h800] = 16'h3000;
        s_pd = c_pd;
        set_en(1'b1);
        s_c0 = c_c0; s_irq = c_irq;
        run_frame();
        chk("R7 cond0 dual A", c_c0 - s_c0, 1);
        chk("R7 no irq when disabled", c_irq - s_irq, 0);
        chk("R3 start buf0 short header", start_addr, 'h20);
        chk("R8 index toggled", buf_idx, 1);
        chk("R10 pal_done after enable", c_pd - s_pd, 1);
        s_c1 = c_c1; s_pd = c_pd;
        run_frame();
        chk("R8 cond1 dual B", c_c1 - s_c1, 1);
        chk("R8 start buf1", start_addr, 'h1200);
        mism = 0;
        for (int k = 0; k < 256; k++) if (pal_m[k] !== mem[12'h800 + k]) mism++;
        chk("R1 palette content buf1", mism, 0);
        chk("R10 no second pal_done", c_pd - s_pd, 0);
        set_en(1'b0);
        set_en(1'b1);
        chk("R8 index reset on enable", buf_idx, 0);
        s_c0 = c_c0; s_pd = c_pd;
        run_frame();
        chk("R8 cond0 after restart", c_c0 - s_c0, 1);
        chk("R10 pal_done after re-enable", c_pd - s_pd, 1);

        wrap_up();
    end
endmodule